// File: doc/BRIEF.md
# Multi-Core Mailbox Channel Controller

This block is a single messaging mailbox that up to 32 processor channels share. Each channel has a one-hot ID, and bit n of every channel-wide vector belongs to channel n. A channel claims the mailbox by writing its ID into the owner register. It then picks the destinations, unmasks the channels that should see interrupts, chooses manual or automatic acknowledge, fills the data words, and raises the message phase through the two-bit send control. Destinations answer either with an explicit acknowledge write or, in automatic mode, by clearing their own destination bits. In automatic mode the mailbox raises the acknowledge by itself once the last destination bit has gone.

Access goes through a simple register port. The accessing channel's ID travels with every access. The port accepts one access on every cycle in which `acc_valid` is high, and it never applies back-pressure, so it has no ready signal. A read returns its data on `rd_valid`/`rd_data` in the following cycle, and the receiver must take it in that cycle. The interrupt-request vectors are plain level outputs. They follow the register state and change in the cycle after the write that alters them.

Top module: `mbox_channel_ctrl`

## Requirements
- R1: After reset, owner, destination status, mask, mode, send and every data word read zero, and both interrupt vectors are zero.
- R2: An owner write (select 0) is taken only when the owner is zero (any value is claimed), or when the write data is zero and the writer's `acc_chan` shares a bit with the current owner (release). Every other owner write leaves the owner unchanged.
- R3: Mask set (select 4) ORs the write data into the mask, and mask clear (select 5) removes the write-data bits. Both are ignored while the owner is zero. The mask reads at select 6.
- R4: Mode (select 7, bit 0 = automatic acknowledge enable) is written only while the owner is nonzero. Otherwise the write is ignored.
- R5: A release of the owner clears the mask and the send control in the same cycle. The destination status is kept.
- R6: Destination set (select 1) ORs bits into the destination status, and destination clear (select 2) removes them. Any channel may do this. The status reads at select 3.
- R7: Send (select 8) stores write-data bits 1:0 and reads back with all higher bits zero. `msg_irq` equals destination AND mask while send bit 0 is set, and `ack_irq` equals owner AND mask while send bit 1 is set. Both are zero otherwise.
- R8: With automatic acknowledge off, a write of 2'b10 to send moves from the message phase to the acknowledge phase, and a write of 2'b01 starts the next message (back-to-back).
- R9: With automatic acknowledge on and send bit 0 set, a destination-clear write that empties a nonzero destination status sets send to 2'b10 in the same update.
- R10: A destination clear that leaves any bit set, or any clear while automatic acknowledge is off, leaves the send control unchanged.
- R11: NUM_DATA data words sit at selects 9 upward. Any channel may read and write them. Selects past the last word, and selects 1, 2, 4 and 5, read zero, and writes to unused selects have no effect.
- R12: A read accepted in one cycle gives `rd_valid` high and `rd_data` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 5 | Register select |
| acc_chan | input | NUM_CH | One-hot ID of the accessing channel |
| acc_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read data |
| msg_irq | output | NUM_CH | Message-phase request per channel |
| ack_irq | output | NUM_CH | Acknowledge-phase request per channel |

## Verification
Assertions check on every cycle that the owner only changes to or from zero, that the mask is empty whenever no owner holds the mailbox, that mode changes only while an owner exists, that an emptying destination clear in automatic mode produces the acknowledge state, and that read data follows each read by one cycle. The scenarios alone show how the vectors are composed against the mask, how the manual and back-to-back handshakes run, that a non-owner cannot take or release the mailbox, that the destination status survives a release, and how the data words and unused selects read back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int SEL_W     = 5;
  localparam int DATA0_IDX = 9;

  typedef enum logic [SEL_W-1:0] {
    SEL_OWNER     = 5'd0,
    SEL_DEST_SET  = 5'd1,
    SEL_DEST_CLR  = 5'd2,
    SEL_DEST_STAT = 5'd3,
    SEL_MASK_SET  = 5'd4,
    SEL_MASK_CLR  = 5'd5,
    SEL_MASK_STAT = 5'd6,
    SEL_MODE      = 5'd7,
    SEL_SEND      = 5'd8
  } sel_e;
endpackage

// File: rtl/mbox_ctrl_regs.sv
module mbox_ctrl_regs
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [NUM_CH-1:0] acc_chan,
  input  logic [DW-1:0]     acc_wdata,
  output logic [NUM_CH-1:0] owner,
  output logic [NUM_CH-1:0] dest,
  output logic [NUM_CH-1:0] mask,
  output logic              auto_ack,
  output logic [1:0]        send
);
  logic [NUM_CH-1:0] wbits;
  logic wr, owner_held, owner_ok, releasing, dest_left, auto_fire;

  assign wbits      = acc_wdata[NUM_CH-1:0];
  assign wr         = acc_valid && acc_write;
  assign owner_held = (owner != '0);
  assign releasing  = wr && (acc_sel == SEL_OWNER) && owner_held &&
                      (wbits == '0) && ((acc_chan & owner) != '0);
  assign owner_ok   = wr && (acc_sel == SEL_OWNER) && (!owner_held || releasing);
  assign dest_left  = ((dest & ~wbits) != '0);
  assign auto_fire  = wr && (acc_sel == SEL_DEST_CLR) && auto_ack && send[0] &&
                      (dest != '0) && !dest_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner    <= '0;
      dest     <= '0;
      mask     <= '0;
      auto_ack <= 1'b0;
      send     <= 2'b00;
    end else begin
      if (owner_ok) owner <= wbits;
      if (wr && acc_sel == SEL_DEST_SET) dest <= dest | wbits;
      if (wr && acc_sel == SEL_DEST_CLR) dest <= dest & ~wbits;
      if (wr && acc_sel == SEL_MODE && owner_held) auto_ack <= acc_wdata[0];
      if (releasing) begin
        mask <= '0;
        send <= 2'b00;
      end else begin
        if (wr && acc_sel == SEL_MASK_SET && owner_held) mask <= mask | wbits;
        if (wr && acc_sel == SEL_MASK_CLR && owner_held) mask <= mask & ~wbits;
        if (wr && acc_sel == SEL_SEND) send <= acc_wdata[1:0];
        else if (auto_fire) send <= 2'b10;
      end
    end
  end

  // R2
  owner_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner)) |-> ($past(owner) == '0 || owner == '0));
  // R3
  mask_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == '0) |-> (mask == '0));
  // R4
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ack != $past(auto_ack)) |-> ($past(owner) != '0));
  // R9
  auto_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_write && acc_sel == SEL_DEST_CLR && auto_ack &&
          send == 2'b01 && dest != '0 && (dest & ~acc_wdata[NUM_CH-1:0]) == '0)
    |-> (send == 2'b10));
endmodule

// File: rtl/mbox_data_bank.sv
module mbox_data_bank
  import mbox_pkg::*;
#(
  parameter int NUM_DATA = 2,
  parameter int DW       = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  input  logic                         acc_write,
  input  logic [SEL_W-1:0]             acc_sel,
  input  logic [DW-1:0]                acc_wdata,
  output logic [NUM_DATA-1:0][DW-1:0]  words
);
  for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(DATA0_IDX + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[i] <= '0;
      else if (acc_valid && acc_write && acc_sel == MY_SEL) words[i] <= acc_wdata;
    end
  end
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen #(
  parameter int NUM_CH = 32
) (
  input  logic [NUM_CH-1:0] owner,
  input  logic [NUM_CH-1:0] dest,
  input  logic [NUM_CH-1:0] mask,
  input  logic [1:0]        send,
  output logic [NUM_CH-1:0] msg_irq,
  output logic [NUM_CH-1:0] ack_irq
);
  assign msg_irq = send[0] ? (dest & mask)  : '0;
  assign ack_irq = send[1] ? (owner & mask) : '0;
endmodule

// File: rtl/mbox_channel_ctrl.sv
module mbox_channel_ctrl
  import mbox_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int DW       = 32,
  parameter int NUM_DATA = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [NUM_CH-1:0] acc_chan,
  input  logic [DW-1:0]     acc_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [NUM_CH-1:0] msg_irq,
  output logic [NUM_CH-1:0] ack_irq
);
  localparam int LAST_SEL = DATA0_IDX + NUM_DATA - 1;

  logic [NUM_CH-1:0] owner, dest, mask;
  logic              auto_ack;
  logic [1:0]        send;
  logic [NUM_DATA-1:0][DW-1:0] words;
  logic [DW-1:0]     rd_mux;
  logic              rd_req;

  mbox_ctrl_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_sel, .acc_chan, .acc_wdata,
    .owner, .dest, .mask, .auto_ack, .send
  );

  mbox_data_bank #(.NUM_DATA(NUM_DATA), .DW(DW)) u_data (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_sel, .acc_wdata, .words
  );

  mbox_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
    .owner, .dest, .mask, .send, .msg_irq, .ack_irq
  );

  always_comb begin
    rd_mux = '0;
    case (acc_sel)
      SEL_OWNER:     rd_mux[NUM_CH-1:0] = owner;
      SEL_DEST_STAT: rd_mux[NUM_CH-1:0] = dest;
      SEL_MASK_STAT: rd_mux[NUM_CH-1:0] = mask;
      SEL_MODE:      rd_mux[0]          = auto_ack;
      SEL_SEND:      rd_mux[1:0]        = send;
      default: begin
        for (int i = 0; i < NUM_DATA; i++)
          if (int'(acc_sel) == DATA0_IDX + i) rd_mux = words[i];
      end
    endcase
  end

  assign rd_req = acc_valid && !acc_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= (int'(acc_sel) <= LAST_SEL) ? rd_mux : '0;
    end
  end

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && !acc_write) |-> rd_valid);
endmodule

// File: tb/mbox_channel_ctrl_tb.sv
module mbox_channel_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [4:0]  acc_sel = '0;
  logic [31:0] acc_chan = '0, acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data, msg_irq, ack_irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mbox_channel_ctrl u_dut (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_sel, .acc_chan, .acc_wdata,
    .rd_valid, .rd_data, .msg_irq, .ack_irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] ch, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_sel = sel; acc_chan = ch; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(input logic [4:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_sel = sel; acc_chan = 32'h1;
    @(negedge clk);
    acc_valid = 0;
    chk({req, " rd_valid (R12)"}, {31'b0, rd_valid}, 32'h1);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 msg_irq", msg_irq, 0);
    chk("R1 ack_irq", ack_irq, 0);
    rd(0, 0, "R1 owner"); rd(3, 0, "R1 dest"); rd(6, 0, "R1 mask");
    rd(7, 0, "R1 mode");  rd(8, 0, "R1 send"); rd(9, 0, "R1 data0");
  endtask

  task automatic t_owner();
    wr(4, 32'h1, 32'h3);  rd(6, 0, "R3 mask set ignored without owner");
    wr(7, 32'h1, 32'h1);  rd(7, 0, "R4 mode ignored without owner");
    wr(0, 32'h1, 32'h1);  rd(0, 32'h1, "R2 claim");
    wr(0, 32'h2, 32'h2);  rd(0, 32'h1, "R2 takeover refused");
    wr(0, 32'h2, 32'h0);  rd(0, 32'h1, "R2 release by non-owner refused");
  endtask

  task automatic t_manual();
    wr(4, 32'h1, 32'h3); wr(1, 32'h1, 32'h2);
    rd(6, 32'h3, "R3 mask set"); rd(3, 32'h2, "R6 dest set");
    wr(8, 32'h1, 32'h1);
    chk("R7 msg_irq", msg_irq, 32'h2); chk("R7 ack_irq idle", ack_irq, 0);
    wr(5, 32'h1, 32'h2); chk("R3 mask clear hides msg", msg_irq, 0);
    wr(4, 32'h1, 32'h2); chk("R3 mask restore", msg_irq, 32'h2);
    wr(8, 32'h2, 32'h2);
    chk("R8 manual ack msg off", msg_irq, 0); chk("R8 manual ack", ack_irq, 32'h1);
    wr(8, 32'h1, 32'h1);
    chk("R8 back-to-back msg", msg_irq, 32'h2); chk("R8 back-to-back ack off", ack_irq, 0);
    wr(8, 32'h1, 32'hFFFF_FFFF); rd(8, 32'h3, "R7 send width");
    wr(2, 32'h2, 32'h2); rd(3, 0, "R6 dest clear");
  endtask

  task automatic t_auto();
    wr(7, 32'h1, 32'h1); rd(7, 32'h1, "R4 mode set");
    wr(4, 32'h1, 32'h7); wr(1, 32'h1, 32'h6); wr(8, 32'h1, 32'h1);
    chk("R7 msg two dests", msg_irq, 32'h6);
    wr(2, 32'h2, 32'h2);
    rd(8, 32'h1, "R10 bits remain, no auto ack");
    chk("R6 partial clear", msg_irq, 32'h4);
    wr(2, 32'h4, 32'h4);
    chk("R9 auto ack", ack_irq, 32'h1);
    rd(8, 32'h2, "R9 send after auto ack");
    rd(3, 0, "R9 dest empty");
  endtask

  task automatic t_auto_off();
    wr(7, 32'h1, 32'h0); wr(1, 32'h1, 32'h2); wr(8, 32'h1, 32'h1);
    wr(2, 32'h2, 32'h2);
    rd(8, 32'h1, "R10 auto off keeps send");
    chk("R10 no ack irq", ack_irq, 0);
  endtask

  task automatic t_data();
    wr(9, 32'h4, 32'hA5A5_0001); wr(10, 32'h8, 32'h1234_5678);
    rd(9, 32'hA5A5_0001, "R11 data0"); rd(10, 32'h1234_5678, "R11 data1");
    wr(11, 32'h1, 32'hDEAD_BEEF); rd(11, 0, "R11 past last word");
    rd(9, 32'hA5A5_0001, "R11 unused write no effect");
    rd(1, 0, "R11 write-only select");
  endtask

  task automatic t_release();
    wr(1, 32'h1, 32'h8); wr(8, 32'h1, 32'h3);
    wr(0, 32'h1, 32'h0);
    rd(0, 0, "R2 release by owner");
    rd(6, 0, "R5 mask cleared"); rd(8, 0, "R5 send cleared");
    rd(3, 32'h8, "R5 dest kept");
    chk("R5 msg_irq", msg_irq, 0); chk("R5 ack_irq", ack_irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_owner(); t_manual(); t_auto(); t_auto_off(); t_data(); t_release();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule